// File: doc/BRIEF.md
# Type-0 Configuration Header Register File

This block holds the standard type-0 configuration header of one PCI Express function. An upstream request decoder presents one configuration access per cycle: the target bus, device and function numbers, a dword register number, 32-bit write data and four byte enables. Exactly one cycle later the block answers with read data, or with an unsupported-request flag when the device and function numbers are not its own. Every accepted request also latches the bus number it carried, so the function learns its own bus number from configuration traffic.

The command register drives the enables used elsewhere in the function. The status register gathers error conditions that the transaction layer reports as one-cycle event pulses, and software clears them by writing ones. Register numbers above the fixed header go out on a shared side port with two selects, one for the capability list window and one for the extended capability window. That port returns its read data in the same cycle, and the block registers it into the response.

Top module: `cfg_hdr_regs`

## Requirements
- R1: After reset the command bits, the status error bits, the captured bus number, the cache line size and the interrupt line are all zero, and no response is pending.
- R2: Read-only identity registers return their parameters: register 0 gives `{DEVICE_ID, VENDOR_ID}`, register 2 gives `{CLASS_CODE, REV_ID}`, register 3 carries the header layout in bits 22:16 and the multi-function flag in bit 23 (latency timer and BIST read 0), register 13 gives the capability pointer in bits 7:0, and register 15 gives the interrupt pin in bits 15:8.
- R3: Register 1 command bits are I/O enable (bit 0), memory enable (bit 1), bus master (bit 2), parity error response (bit 6), system error enable (bit 8) and interrupt disable (bit 10). Bits 0, 1, 2 and 6 are written only when byte enable 0 is set, bits 8 and 10 only when byte enable 1 is set. The first three and bit 10 also appear on dedicated output pins.
- R4: Register 1 bit 19 reads the level of `intx_pending`, and bit 20 always reads 1.
- R5: Event pulses set status bits in register 1: a received completion with completer abort sets bit 28, a received completion with unsupported request sets bit 29, a sent completion with completer abort sets bit 27, a signalled system error sets bit 30 and a detected parity error sets bit 31.
- R6: A poisoned packet, sent or received, sets status bit 24 only while command bit 6 is 1.
- R7: Writing 1 to status bits 24 and 27 to 31 of register 1 clears them only when byte enable 3 is set. An event that arrives in the same cycle as the clear wins, and the bit stays set.
- R8: Cache line size (register 3 bits 7:0) and interrupt line (register 15 bits 7:0) are written under byte enable 0. All other header fields ignore writes.
- R9: For an accepted access, register numbers 16 to 63 raise `cap_sel` and 64 to 1023 raise `ext_sel`, with the register number, write flag, data and byte enables on the `fwd_*` pins in the same cycle. A forwarded read returns the side port's data. Header registers not listed in R2 to R8 read 0.
- R10: A request is accepted only when its device and function numbers equal `DEV_NUM` and `FN_NUM`. An accepted request loads `bus_num` from `req_bus`. A rejected request returns `rsp_ur` = 1 with data 0 and changes no state and raises no select.
- R11: `rsp_valid` is high exactly in the cycle after each cycle with `req_valid` high. Write responses return data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration access present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device number |
| req_fn | input | 3 | Target function number |
| req_reg | input | REG_W | Dword register number |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_ur | output | 1 | Unsupported request (ID mismatch) |
| cap_sel | output | 1 | Access falls in capability list window |
| ext_sel | output | 1 | Access falls in extended capability window |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_reg | output | REG_W | Forwarded register number |
| fwd_wdata | output | 32 | Forwarded write data |
| fwd_be | output | 4 | Forwarded byte enables |
| cap_rdata | input | 32 | Capability window read data (same cycle) |
| ext_rdata | input | 32 | Extended window read data (same cycle) |
| ev_rx_cpl_ca | input | 1 | Received completion, completer abort |
| ev_rx_cpl_ur | input | 1 | Received completion, unsupported request |
| ev_tx_cpl_ca | input | 1 | Sent completion, completer abort |
| ev_rx_poison | input | 1 | Received poisoned packet |
| ev_tx_poison | input | 1 | Sent poisoned packet |
| ev_serr_sent | input | 1 | System error signalled |
| ev_parity_det | input | 1 | Parity error detected |
| intx_pending | input | 1 | Legacy interrupt pending level |
| bus_num | output | 8 | Captured bus number |
| cmd_io_en | output | 1 | I/O space enable |
| cmd_mem_en | output | 1 | Memory space enable |
| cmd_master_en | output | 1 | Bus master enable |
| cmd_intx_dis | output | 1 | Interrupt disable |

## Verification
The bench builds the block with non-zero device and function numbers (3 and 1), so a zero-filled request ID does not match by accident, and the rejection path is reached by changing one field. It gives distinct identity values and sets the multi-function flag, so every packed field of registers 0, 2 and 3 is visible and in a known position. It keeps the default 10-bit register number, so the window edges 15/16, 63/64 and the top register 1023 can all be driven, and the side-port data it returns embeds the register number, which exposes a wrong forwarding address.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  typedef enum logic [1:0] {
    WIN_HDR  = 2'd0,
    WIN_CAP  = 2'd1,
    WIN_EXT  = 2'd2,
    WIN_NONE = 2'd3
  } cfg_win_e;

  typedef struct packed {
    logic intd;
    logic serr;
    logic perr;
    logic bm;
    logic mem;
    logic io;
  } cfg_cmd_t;

  typedef struct packed {
    logic dpe;
    logic sse;
    logic rma;
    logic rta;
    logic sta;
    logic mdpe;
  } cfg_sts_t;

  // Window of a register number; the header always spans 0..hdr_end-1.
  function automatic cfg_win_e win_of(int unsigned r, int unsigned hdr_end,
                                      int unsigned ext_lo, int unsigned ext_end);
    if (r < hdr_end)      return WIN_HDR;
    else if (r < ext_lo)  return WIN_CAP;
    else if (r < ext_end) return WIN_EXT;
    else                  return WIN_NONE;
  endfunction

  // Dword image of the command/status register.
  function automatic logic [31:0] pack_cmd_sts(cfg_cmd_t c, cfg_sts_t s, logic intx);
    logic [31:0] w;
    w     = '0;
    w[0]  = c.io;
    w[1]  = c.mem;
    w[2]  = c.bm;
    w[6]  = c.perr;
    w[8]  = c.serr;
    w[10] = c.intd;
    w[19] = intx;
    w[20] = 1'b1;
    w[24] = s.mdpe;
    w[27] = s.sta;
    w[28] = s.rta;
    w[29] = s.rma;
    w[30] = s.sse;
    w[31] = s.dpe;
    return w;
  endfunction

  // Bits of a write that request a status clear, gated by the top byte lane.
  function automatic cfg_sts_t w1c_mask(logic [31:0] d, logic lane3);
    cfg_sts_t m;
    m.mdpe = lane3 & d[24];
    m.sta  = lane3 & d[27];
    m.rta  = lane3 & d[28];
    m.rma  = lane3 & d[29];
    m.sse  = lane3 & d[30];
    m.dpe  = lane3 & d[31];
    return m;
  endfunction

endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned REG_W   = 10,
  parameter int unsigned HDR_END = 16,
  parameter int unsigned EXT_LO  = 64,
  parameter int unsigned EXT_END = 1024
) (
  input  logic [REG_W-1:0] reg_num,
  output cfg_win_e         win,
  output logic [3:0]       hdr_idx
);
  assign win     = win_of(32'(reg_num), HDR_END, EXT_LO, EXT_END);
  assign hdr_idx = reg_num[3:0];
endmodule

// File: rtl/cfg_fn_match.sv
module cfg_fn_match #(
  parameter logic [4:0] DEV_NUM = 5'd0,
  parameter logic [2:0] FN_NUM  = 3'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [7:0] req_bus,
  input  logic [4:0] req_dev,
  input  logic [2:0] req_fn,
  output logic       hit,
  output logic [7:0] bus_q
);
  assign hit = (req_dev == DEV_NUM) && (req_fn == FN_NUM);

  always_ff @(posedge clk) begin
    if (!rst_n)                bus_q <= '0;
    else if (req_valid && hit) bus_q <= req_bus;
  end

  p_bus_capture_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit) |=> (bus_q == $past(req_bus)));
  p_bus_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && hit) |=> $stable(bus_q));
endmodule

// File: rtl/cfg_cmd_status.sv
module cfg_cmd_status
  import cfg_hdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic        ev_rx_cpl_ca,
  input  logic        ev_rx_cpl_ur,
  input  logic        ev_tx_cpl_ca,
  input  logic        ev_rx_poison,
  input  logic        ev_tx_poison,
  input  logic        ev_serr_sent,
  input  logic        ev_parity_det,
  input  logic        intx,
  output cfg_cmd_t    cmd,
  output cfg_sts_t    sts,
  output logic [31:0] word
);
  cfg_sts_t set_ev;
  cfg_sts_t clr_ev;
  logic     unused_wbits;

  assign unused_wbits = ^{wdata[5:3], wdata[7], wdata[9], wdata[23:11], wdata[26:25], be[2]};

  always_comb begin
    set_ev.mdpe = cmd.perr & (ev_rx_poison | ev_tx_poison);
    set_ev.sta  = ev_tx_cpl_ca;
    set_ev.rta  = ev_rx_cpl_ca;
    set_ev.rma  = ev_rx_cpl_ur;
    set_ev.sse  = ev_serr_sent;
    set_ev.dpe  = ev_parity_det;
    clr_ev      = w1c_mask(wdata, wr_en & be[3]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd <= '0;
      sts <= '0;
    end else begin
      if (wr_en && be[0]) begin
        cmd.io   <= wdata[0];
        cmd.mem  <= wdata[1];
        cmd.bm   <= wdata[2];
        cmd.perr <= wdata[6];
      end
      if (wr_en && be[1]) begin
        cmd.serr <= wdata[8];
        cmd.intd <= wdata[10];
      end
      sts <= set_ev | (sts & ~clr_ev);
    end
  end

  assign word = pack_cmd_sts(cmd, sts, intx);

  p_rx_ca_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_cpl_ca |=> sts.rta);
  p_tx_ca_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_cpl_ca |=> sts.sta);
  p_poison_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts.mdpe && !cmd.perr) |=> !sts.mdpe);
  p_lane1_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && be[1]) |=> ($stable(cmd.serr) && $stable(cmd.intd)));
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && be[3] && wdata[29] && !ev_rx_cpl_ur) |=> !sts.rma);
  p_no_lane3_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sts.dpe && !(wr_en && be[3])) |=> sts.dpe);
endmodule

// File: rtl/cfg_hdr_regs.sv
module cfg_hdr_regs
  import cfg_hdr_pkg::*;
#(
  parameter int unsigned REG_W      = 10,
  parameter int unsigned EXT_LO     = 64,
  parameter int unsigned EXT_END    = 1024,
  parameter logic [15:0] VENDOR_ID  = 16'h0001,
  parameter logic [15:0] DEVICE_ID  = 16'h0001,
  parameter logic [7:0]  REV_ID     = 8'h00,
  parameter logic [23:0] CLASS_CODE = 24'h000000,
  parameter logic [6:0]  HDR_LAYOUT = 7'h00,
  parameter logic        MULTI_FN   = 1'b0,
  parameter logic [7:0]  CAP_PTR    = 8'h40,
  parameter logic [7:0]  INT_PIN    = 8'h01,
  parameter logic [4:0]  DEV_NUM    = 5'd0,
  parameter logic [2:0]  FN_NUM     = 3'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [7:0]       req_bus,
  input  logic [4:0]       req_dev,
  input  logic [2:0]       req_fn,
  input  logic [REG_W-1:0] req_reg,
  input  logic [31:0]      req_wdata,
  input  logic [3:0]       req_be,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_ur,
  output logic             cap_sel,
  output logic             ext_sel,
  output logic             fwd_write,
  output logic [REG_W-1:0] fwd_reg,
  output logic [31:0]      fwd_wdata,
  output logic [3:0]       fwd_be,
  input  logic [31:0]      cap_rdata,
  input  logic [31:0]      ext_rdata,
  input  logic             ev_rx_cpl_ca,
  input  logic             ev_rx_cpl_ur,
  input  logic             ev_tx_cpl_ca,
  input  logic             ev_rx_poison,
  input  logic             ev_tx_poison,
  input  logic             ev_serr_sent,
  input  logic             ev_parity_det,
  input  logic             intx_pending,
  output logic [7:0]       bus_num,
  output logic             cmd_io_en,
  output logic             cmd_mem_en,
  output logic             cmd_master_en,
  output logic             cmd_intx_dis
);
  localparam int unsigned HDR_END = 16;

  logic        hit;
  logic        acc;
  cfg_win_e    win;
  logic [3:0]  hdr_idx;
  logic        hdr_wr;
  logic        wr_cmd;
  cfg_cmd_t    cmd;
  cfg_sts_t    sts;
  logic [31:0] cmd_word;
  logic [7:0]  cache_line_q;
  logic [7:0]  int_line_q;
  logic [31:0] rd_mux;

  cfg_fn_match #(.DEV_NUM(DEV_NUM), .FN_NUM(FN_NUM)) u_match (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_bus(req_bus),
    .req_dev(req_dev), .req_fn(req_fn), .hit(hit), .bus_q(bus_num));

  cfg_win_decode #(.REG_W(REG_W), .HDR_END(HDR_END), .EXT_LO(EXT_LO), .EXT_END(EXT_END)) u_dec (
    .reg_num(req_reg), .win(win), .hdr_idx(hdr_idx));

  assign acc    = req_valid && hit;
  assign hdr_wr = acc && req_write && (win == WIN_HDR);
  assign wr_cmd = hdr_wr && (hdr_idx == 4'd1);

  cfg_cmd_status u_cs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_cmd), .wdata(req_wdata), .be(req_be),
    .ev_rx_cpl_ca(ev_rx_cpl_ca), .ev_rx_cpl_ur(ev_rx_cpl_ur), .ev_tx_cpl_ca(ev_tx_cpl_ca),
    .ev_rx_poison(ev_rx_poison), .ev_tx_poison(ev_tx_poison), .ev_serr_sent(ev_serr_sent),
    .ev_parity_det(ev_parity_det), .intx(intx_pending),
    .cmd(cmd), .sts(sts), .word(cmd_word));

  assign cmd_io_en     = cmd.io;
  assign cmd_mem_en    = cmd.mem;
  assign cmd_master_en = cmd.bm;
  assign cmd_intx_dis  = cmd.intd;

  // Side port toward the capability structures.
  assign cap_sel   = acc && (win == WIN_CAP);
  assign ext_sel   = acc && (win == WIN_EXT);
  assign fwd_write = req_write;
  assign fwd_reg   = req_reg;
  assign fwd_wdata = req_wdata;
  assign fwd_be    = req_be;

  // Writable byte-wide header fields.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cache_line_q <= '0;
      int_line_q   <= '0;
    end else if (hdr_wr && req_be[0]) begin
      if (hdr_idx == 4'd3)  cache_line_q <= req_wdata[7:0];
      if (hdr_idx == 4'd15) int_line_q   <= req_wdata[7:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (win)
      WIN_HDR: begin
        case (hdr_idx)
          4'd0:    rd_mux = {DEVICE_ID, VENDOR_ID};
          4'd1:    rd_mux = cmd_word;
          4'd2:    rd_mux = {CLASS_CODE, REV_ID};
          4'd3:    rd_mux = {8'h00, MULTI_FN, HDR_LAYOUT, 8'h00, cache_line_q};
          4'd13:   rd_mux = {24'h0, CAP_PTR};
          4'd15:   rd_mux = {16'h0, INT_PIN, int_line_q};
          default: rd_mux = '0;
        endcase
      end
      WIN_CAP:  rd_mux = cap_rdata;
      WIN_EXT:  rd_mux = ext_rdata;
      WIN_NONE: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ur    <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ur    <= req_valid && !hit;
      rsp_rdata <= (acc && !req_write) ? rd_mux : '0;
    end
  end

  p_rsp_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_rsp_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_sel_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_sel, ext_sel}));
  p_reject_ur_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> (rsp_ur && rsp_rdata == '0));
  p_reject_no_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> ($stable(cmd_io_en) && $stable(cmd_mem_en) && $stable(cmd_master_en)));
endmodule

// File: tb/tb_cfg_hdr_regs.sv
module tb_cfg_hdr_regs;
  localparam logic [4:0] DEVN = 5'd3;
  localparam logic [2:0] FNN  = 3'd1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_bus = '0;
  logic [4:0]  req_dev = '0;
  logic [2:0]  req_fn = '0;
  logic [9:0]  req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        rsp_valid, rsp_ur, cap_sel, ext_sel, fwd_write;
  logic [31:0] rsp_rdata, fwd_wdata, cap_rdata, ext_rdata;
  logic [9:0]  fwd_reg;
  logic [3:0]  fwd_be;
  logic        ev_rx_cpl_ca = 0, ev_rx_cpl_ur = 0, ev_tx_cpl_ca = 0, ev_rx_poison = 0;
  logic        ev_tx_poison = 0, ev_serr_sent = 0, ev_parity_det = 0, intx_pending = 0;
  logic [7:0]  bus_num;
  logic        cmd_io_en, cmd_mem_en, cmd_master_en, cmd_intx_dis;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_rd_q[$];
  logic        exp_ur_q[$];
  string       exp_tag_q[$];

  always #10 clk = ~clk;

  // Side-port model: data embeds the forwarded register number.
  assign cap_rdata = 32'hC0DE_0000 | {22'h0, fwd_reg};
  assign ext_rdata = 32'hE0E0_0000 | {22'h0, fwd_reg};

  cfg_hdr_regs #(
    .VENDOR_ID(16'hA5C3), .DEVICE_ID(16'h7E21), .REV_ID(8'h04), .CLASS_CODE(24'h020000),
    .HDR_LAYOUT(7'h00), .MULTI_FN(1'b1), .CAP_PTR(8'h40), .INT_PIN(8'h01),
    .DEV_NUM(DEVN), .FN_NUM(FNN)
  ) dut (.*);

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  // Driver: one access, expected response queued for the monitor.
  task automatic access(input logic wr, input logic [4:0] dv, input logic [2:0] fn,
                        input logic [7:0] bus, input int r, input logic [31:0] wd,
                        input logic [3:0] be, input logic [31:0] exp_rd, input string tag);
    bit m;
    bit e_cap, e_ext;
    m     = (dv == DEVN) && (fn == FNN);
    e_cap = m && (r >= 16) && (r < 64);
    e_ext = m && (r >= 64);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_dev = dv; req_fn = fn; req_bus = bus;
    req_reg = 10'(r); req_wdata = wd; req_be = be;
    exp_rd_q.push_back((m && !wr) ? exp_rd : 32'h0);
    exp_ur_q.push_back(!m);
    exp_tag_q.push_back(tag);
    #1;
    chk(cap_sel === e_cap, {tag, " R9 cap_sel"}, 32'(cap_sel), 32'(e_cap));
    chk(ext_sel === e_ext, {tag, " R9 ext_sel"}, 32'(ext_sel), 32'(e_ext));
    if (e_cap || e_ext) begin
      chk(fwd_reg === 10'(r), {tag, " R9 fwd_reg"}, 32'(fwd_reg), 32'(r));
      chk(fwd_write === wr && fwd_wdata === wd && fwd_be === be, {tag, " R9 fwd fields"},
          fwd_wdata, wd);
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Monitor / scoreboard.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (rst_n) begin
        if (rsp_valid) begin
          if (exp_rd_q.size() == 0) begin
            chk(1'b0, "R11 response without request", 32'(rsp_valid), 32'h0);
          end else begin
            logic [31:0] erd;
            logic        eur;
            string       tg;
            erd = exp_rd_q.pop_front();
            eur = exp_ur_q.pop_front();
            tg  = exp_tag_q.pop_front();
            chk(rsp_rdata === erd, {tg, " rdata"}, rsp_rdata, erd);
            chk(rsp_ur === eur, {tg, " R10 ur flag"}, 32'(rsp_ur), 32'(eur));
          end
        end else if (exp_rd_q.size() != 0) begin
          chk(1'b0, "R11 missing response", 32'(rsp_valid), 32'h1);
          void'(exp_rd_q.pop_front());
          void'(exp_ur_q.pop_front());
          void'(exp_tag_q.pop_front());
        end
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rsp_valid === 1'b0 && bus_num === 8'h0, "R1 reset outputs", {23'h0, rsp_valid, bus_num}, 32'h0);
    chk({cmd_io_en, cmd_mem_en, cmd_master_en, cmd_intx_dis} === 4'b0, "R1 reset command pins",
        32'({cmd_io_en, cmd_mem_en, cmd_master_en, cmd_intx_dis}), 32'h0);
    rst_n = 1'b1;

    // R1/R4: reset status, capability list bit; R10 bus capture
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'h0010_0000, "R1 R4 reg1 after reset");
    @(negedge clk);
    chk(bus_num === 8'h05, "R10 bus captured", 32'(bus_num), 32'h05);
    access(0, DEVN, FNN, 8'h05, 3, 0, 4'hF, 32'h0080_0000, "R1 reg3 after reset");
    access(0, DEVN, FNN, 8'h05, 15, 0, 4'hF, 32'h0000_0100, "R1 R2 reg15 after reset");

    // R2 identity
    access(0, DEVN, FNN, 8'h05, 0, 0, 4'hF, 32'h7E21_A5C3, "R2 reg0");
    access(0, DEVN, FNN, 8'h05, 2, 0, 4'hF, 32'h0200_0004, "R2 reg2");
    access(0, DEVN, FNN, 8'h05, 13, 0, 4'hF, 32'h0000_0040, "R2 reg13");
    access(0, DEVN, FNN, 8'h05, 5, 0, 4'hF, 32'h0, "R9 unlisted header reg");
    access(0, DEVN, FNN, 8'h05, 14, 0, 4'hF, 32'h0, "R9 unlisted header reg14");

    // R3 command lanes
    access(1, DEVN, FNN, 8'h05, 1, 32'hFFFF_FFFF, 4'b0001, 32'h0, "R3 lane0 write");
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'h0010_0047, "R3 lane0 bits only");
    chk({cmd_io_en, cmd_mem_en, cmd_master_en, cmd_intx_dis} === 4'b1110, "R3 command pins",
        32'({cmd_io_en, cmd_mem_en, cmd_master_en, cmd_intx_dis}), 32'hE);
    access(1, DEVN, FNN, 8'h05, 1, 32'h0000_0500, 4'b0010, 32'h0, "R3 lane1 write");
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'h0010_0547, "R3 lane1 bits");
    chk(cmd_intx_dis === 1'b1, "R3 interrupt disable pin", 32'(cmd_intx_dis), 32'h1);

    // R4/R5 events
    @(negedge clk); ev_rx_cpl_ca = 1; @(negedge clk); ev_rx_cpl_ca = 0;
    @(negedge clk); ev_rx_cpl_ur = 1; @(negedge clk); ev_rx_cpl_ur = 0;
    @(negedge clk); ev_tx_cpl_ca = 1; @(negedge clk); ev_tx_cpl_ca = 0;
    intx_pending = 1;
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'h3818_0547, "R4 R5 abort bits and intx");

    // R6 poison with parity response on; R5 serr/parity
    @(negedge clk); ev_rx_poison = 1; @(negedge clk); ev_rx_poison = 0;
    @(negedge clk); ev_serr_sent = 1; ev_parity_det = 1;
    @(negedge clk); ev_serr_sent = 0; ev_parity_det = 0;
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'hF918_0547, "R5 R6 all error bits");

    // R7 clear gating and priority
    access(1, DEVN, FNN, 8'h05, 1, 32'hFF00_0547, 4'b0111, 32'h0, "R7 write without lane3");
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'hF918_0547, "R7 no clear without lane3");
    access(1, DEVN, FNN, 8'h05, 1, 32'h1000_0000, 4'b1000, 32'h0, "R7 clear bit28");
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'hE918_0547, "R7 bit28 cleared only");
    ev_rx_cpl_ur = 1;
    access(1, DEVN, FNN, 8'h05, 1, 32'h2000_0000, 4'b1000, 32'h0, "R7 clear vs event");
    ev_rx_cpl_ur = 0;
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'hE918_0547, "R7 event wins over clear");
    access(1, DEVN, FNN, 8'h05, 1, 32'hFF00_0000, 4'b1000, 32'h0, "R7 clear all");
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'h0018_0547, "R7 all cleared");

    // R6 poison with parity response off
    access(1, DEVN, FNN, 8'h05, 1, 32'h0000_0007, 4'b0001, 32'h0, "R6 disable parity response");
    @(negedge clk); ev_tx_poison = 1; ev_rx_poison = 1;
    @(negedge clk); ev_tx_poison = 0; ev_rx_poison = 0;
    access(0, DEVN, FNN, 8'h05, 1, 0, 4'hF, 32'h0018_0507, "R6 poison ignored");

    // R8 writable fields, read-only ignore
    access(1, DEVN, FNN, 8'h05, 3, 32'hFFFF_FFFF, 4'hF, 32'h0, "R8 reg3 write");
    access(0, DEVN, FNN, 8'h05, 3, 0, 4'hF, 32'h0080_00FF, "R8 cache line only");
    access(1, DEVN, FNN, 8'h05, 3, 32'h0, 4'b1110, 32'h0, "R8 reg3 write no lane0");
    access(0, DEVN, FNN, 8'h05, 3, 0, 4'hF, 32'h0080_00FF, "R8 cache line kept");
    access(1, DEVN, FNN, 8'h05, 15, 32'hFFFF_FFFF, 4'hF, 32'h0, "R8 reg15 write");
    access(0, DEVN, FNN, 8'h05, 15, 0, 4'hF, 32'h0000_01FF, "R8 interrupt line");
    access(1, DEVN, FNN, 8'h05, 0, 32'h0, 4'hF, 32'h0, "R8 write to ID");
    access(0, DEVN, FNN, 8'h05, 0, 0, 4'hF, 32'h7E21_A5C3, "R8 ID unchanged");

    // R9 forwarding windows
    access(0, DEVN, FNN, 8'h05, 16, 0, 4'hF, 32'hC0DE_0010, "R9 cap low edge");
    access(0, DEVN, FNN, 8'h05, 63, 0, 4'hF, 32'hC0DE_003F, "R9 cap high edge");
    access(0, DEVN, FNN, 8'h05, 64, 0, 4'hF, 32'hE0E0_0040, "R9 ext low edge");
    access(0, DEVN, FNN, 8'h05, 1023, 0, 4'hF, 32'hE0E0_03FF, "R9 ext top");
    access(1, DEVN, FNN, 8'h05, 20, 32'h1234_5678, 4'b0101, 32'h0, "R9 cap write");

    // R10 mismatch
    access(0, 5'd2, FNN, 8'h09, 0, 0, 4'hF, 32'h0, "R10 device mismatch read");
    access(1, DEVN, 3'd0, 8'h09, 1, 32'h0, 4'hF, 32'h0, "R10 function mismatch write");
    access(0, 5'd2, FNN, 8'h09, 20, 0, 4'hF, 32'h0, "R10 mismatch no forward");
    @(negedge clk);
    chk(bus_num === 8'h05, "R10 bus kept on mismatch", 32'(bus_num), 32'h05);
    access(0, DEVN, FNN, 8'h2A, 1, 0, 4'hF, 32'h0018_0507, "R10 state kept on mismatch");
    @(negedge clk);
    chk(bus_num === 8'h2A, "R10 bus recaptured", 32'(bus_num), 32'h2A);
    chk(rsp_valid === 1'b0, "R11 idle after response", 32'(rsp_valid), 32'h0);

    repeat (3) @(negedge clk);
    chk(exp_rd_q.size() == 0, "R11 all responses seen", 32'(exp_rd_q.size()), 32'h0);
    summary();
    $finish;
  end
endmodule